// File: doc/BRIEF.md
# Key-Protected Reset Controller

This block is a small register-mapped reset controller. Four 32-bit registers sit behind a request/response register port: a cause register that records why the last reset pulse happened, a control register that holds the unlock key field and the software reset trigger, a configuration register that picks soft or hard reset, and an isolation register that drives per-clock isolation enables. The control and configuration registers are guarded. Software must first write a 16-bit unlock key. The next write to either guarded register then takes effect, and the guard closes again after that write.

A reset starts in one of three ways: software clears the trigger bit while the guard is open, the watchdog input is raised, or the external input is raised. Each start produces a fixed-length reset request pulse and records which sources started it. Any attempt to write a guarded register while the guard is closed is dropped and leaves a sticky violation flag in the cause register. Software clears cause bits by writing ones to them.

The register port follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each taken request returns exactly one response. The response holds its data on `rsp_rdata` until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` stays low, so back-pressure on the response side stalls new requests.

Top module: `rstc_top`

## Requirements
- R1: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` is low while a response is pending and `rsp_ready` is low. Every accepted request yields one response whose `rsp_rdata` stays stable until `rsp_ready` is high.
- R2: Address bits [3:2] select the register: 0x0 cause, 0x4 control, 0x8 configuration, 0xC isolation. Address bits [1:0] are ignored. A write returns `rsp_rdata` 0. A read returns the register value from before the edge on which the read is accepted.
- R3: After reset, cause reads 0, control reads 0x0001_0000, configuration reads 0, isolation reads 0xFFFF_FFFF, `rst_req` is low and `soft_mode` is low.
- R4: A control write with wdata[15:0] = 0x5A69 opens the guard and never starts a reset. Control bits [15:0] read 0x0001 while the guard is open and 0x0000 while it is closed.
- R5: While the guard is open, the first write to control or configuration is the one write it permits, and the guard then closes. Reads, and writes to cause or isolation, leave the guard state unchanged.
- R6: A configuration write, or a control write without the key, made while the guard is closed changes nothing else and sets cause bit 3 (violation). Bit 3 stays set until it is cleared by software.
- R7: A control write without the key, made while the guard is open, starts a software reset when wdata[16] is 0 and does nothing besides closing the guard when wdata[16] is 1.
- R8: `rst_req` goes high from the edge that accepts the starting event and stays high for exactly PULSE_LEN (16) cycles. Control bit 16 reads 0 while the pulse is active and 1 otherwise.
- R9: `wdog_req` or `ext_req` sampled high while no pulse is active starts a pulse. Any trigger that arrives while a pulse is active is ignored.
- R10: At each pulse start, cause bits [2:0] are replaced by the sources that started it: bit 0 software, bit 1 watchdog, bit 2 external. Bit 3 is kept.
- R11: A write to the cause register clears every cause bit whose wdata bit is 1 and leaves the other cause bits as they were.
- R12: `soft_mode` is high exactly when the configuration register holds 0x0000_300F. The value 0 selects hard reset, with `soft_mode` low.
- R13: The isolation register can be written without the key and drives `iso_en`. Writing 0 clears every isolation enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| wdog_req | input | 1 | Watchdog reset request |
| ext_req | input | 1 | External reset request |
| rst_req | output | 1 | Reset request pulse |
| soft_mode | output | 1 | Soft reset selected |
| iso_en | output | 32 | Isolation enables |

## Verification
Some properties are checked on every cycle: the pulse length of `rst_req`, response stability and the stall of `req_ready` under back-pressure, the stickiness of the violation flag, and that every pulse start leaves a recorded cause. Other behaviour only the bench scenarios can show. These are the key sequencing (open, consume, close), a locked write being dropped, the trigger-bit polarity, triggers that are ignored during an active pulse, write-one-to-clear masking, address aliasing, and the soft/hard configuration decode.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 4;
  localparam int CAUSE_W = 4;
  localparam int NSRC = 3;
  localparam int TRIG_BIT = 16;
  localparam logic [15:0] UNLOCK_KEY = 16'h5A69;
  localparam logic [REG_W-1:0] SOFT_PATTERN = 32'h0000_300F;
  localparam int C_SW = 0;
  localparam int C_WDOG = 1;
  localparam int C_EXT = 2;
  localparam int C_VIOL = 3;

  typedef enum logic [1:0] {
    SEL_CAUSE = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_ISO   = 2'd3
  } rstc_sel_e;
endpackage

// File: rtl/rstc_bus_port.sv
module rstc_bus_port
  import rstc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic [1:0]       req_sel_bits,
  input  logic             rsp_ready,
  input  logic [REG_W-1:0] rdata_in,
  output logic             req_ready,
  output logic             acc,
  output rstc_sel_e        sel,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_rdata
);
  logic             rsp_valid_q;
  logic [REG_W-1:0] rsp_rdata_q;

  assign sel       = rstc_sel_e'(req_sel_bits);
  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (acc) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= req_we ? '0 : rdata_in;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rstc_key_gate.sv
module rstc_key_gate
  import rstc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  rstc_sel_e        sel,
  input  logic [REG_W-1:0] wdata,
  output logic             unlocked,
  output logic             cfg_commit,
  output logic             viol_set,
  output logic             sw_trig
);
  logic open_q, open_d;
  logic key_hit, ctrl_wr, cfg_wr;

  assign key_hit  = (wdata[15:0] == UNLOCK_KEY);
  assign ctrl_wr  = wr && (sel == SEL_CTRL);
  assign cfg_wr   = wr && (sel == SEL_CFG);
  assign unlocked = open_q;

  always_comb begin
    open_d     = open_q;
    cfg_commit = 1'b0;
    viol_set   = 1'b0;
    sw_trig    = 1'b0;
    if (ctrl_wr && key_hit) begin
      open_d = 1'b1;
    end else if (ctrl_wr) begin
      if (open_q) sw_trig = !wdata[TRIG_BIT];
      else        viol_set = 1'b1;
      open_d = 1'b0;
    end else if (cfg_wr) begin
      if (open_q) cfg_commit = 1'b1;
      else        viol_set = 1'b1;
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/rstc_pulse_gen.sv
module rstc_pulse_gen #(
  parameter int PULSE_LEN = 16,
  parameter int NSRC      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  output logic            active,
  output logic            start,
  output logic [NSRC-1:0] start_src
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;

  assign active    = (cnt_q != '0);
  assign start     = (|src) && !active;
  assign start_src = active ? '0 : src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= LOAD;
    else if (active) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int PULSE_LEN = 16,
  parameter logic [31:0] ISO_RESET = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [REG_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_W-1:0]  rsp_rdata,
  input  logic              wdog_req,
  input  logic              ext_req,
  output logic              rst_req,
  output logic              soft_mode,
  output logic [REG_W-1:0]  iso_en
);
  logic             acc, wr, unlocked, cfg_commit, viol_set, sw_trig;
  logic             pulse_active, pulse_start;
  logic [NSRC-1:0]  trig_src, start_src;
  rstc_sel_e        sel;
  logic [REG_W-1:0] rdata_mux, cfg_q, iso_q;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic [1:0]       unused_addr_lsb;

  assign unused_addr_lsb = req_addr[1:0];

  rstc_bus_port u_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_sel_bits(req_addr[3:2]), .rsp_ready(rsp_ready), .rdata_in(rdata_mux),
    .req_ready(req_ready), .acc(acc), .sel(sel),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign wr = acc && req_we;

  rstc_key_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wr(wr), .sel(sel), .wdata(req_wdata),
    .unlocked(unlocked), .cfg_commit(cfg_commit), .viol_set(viol_set),
    .sw_trig(sw_trig)
  );

  assign trig_src = {ext_req, wdog_req, sw_trig};

  rstc_pulse_gen #(.PULSE_LEN(PULSE_LEN), .NSRC(NSRC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .src(trig_src), .active(pulse_active),
    .start(pulse_start), .start_src(start_src)
  );

  assign rst_req   = pulse_active;
  assign soft_mode = (cfg_q == SOFT_PATTERN);
  assign iso_en    = iso_q;

  always_comb begin
    cause_d = cause_q;
    if (wr && sel == SEL_CAUSE) cause_d = cause_q & ~req_wdata[CAUSE_W-1:0];
    if (pulse_start) cause_d[NSRC-1:0] = start_src;
    if (viol_set) cause_d[C_VIOL] = 1'b1;
  end

  always_comb begin
    unique case (sel)
      SEL_CAUSE: rdata_mux = {{(REG_W-CAUSE_W){1'b0}}, cause_q};
      SEL_CTRL:  rdata_mux = {{(REG_W-TRIG_BIT-1){1'b0}}, !pulse_active,
                             15'd0, unlocked};
      SEL_CFG:   rdata_mux = cfg_q;
      default:   rdata_mux = iso_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      cfg_q   <= '0;
      iso_q   <= ISO_RESET;
    end else begin
      cause_q <= cause_d;
      if (cfg_commit) cfg_q <= req_wdata;
      if (wr && sel == SEL_ISO) iso_q <= req_wdata;
    end
  end
endmodule

// File: rtl/rstc_top_chk.sv
module rstc_top_chk #(
  parameter int PULSE_LEN = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_we,
  input logic [1:0] req_sel,
  input logic       clr_viol,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic       rst_req,
  input logic [3:0] cause_q
);
  localparam int HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (rst_req) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  p_pulse_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> hi_cnt < HW'(PULSE_LEN));

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> hi_cnt == HW'(PULSE_LEN));

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_cause_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (cause_q[2:0] != 3'b000));

  p_viol_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[3] && !(req_valid && req_ready && req_we && req_sel == 2'd0 && clr_viol)
    |=> cause_q[3]);
endmodule

bind rstc_top rstc_top_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_we(req_we), .req_sel(req_addr[3:2]), .clr_viol(req_wdata[3]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rst_req(rst_req), .cause_q(cause_q)
);

// File: tb/rstc_top_tb.sv
`timescale 1ns/1ps
module rstc_top_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [3:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic wdog_req = 1'b0, ext_req = 1'b0;
  logic req_ready, rsp_valid, rst_req, soft_mode;
  logic [31:0] rsp_rdata, iso_en;

  rstc_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wdog_req(wdog_req), .ext_req(ext_req), .rst_req(rst_req),
    .soft_mode(soft_mode), .iso_en(iso_en)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit bp = 1'b0;
  int run = 0, last_len = 0, pulses = 0;
  logic prev_req = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [3:0] addr, input logic [31:0] wd,
                      input logic [31:0] exp, input string tag);
    exp_q.push_back(we ? 32'h0 : exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_pulse_end();
    while (rst_req) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    rsp_ready = bp ? ~rsp_ready : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R1 response without request", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
    if (rst_req) run++;
    else if (run != 0) begin last_len = run; run = 0; end
    if (rst_req && !prev_req) pulses++;
    prev_req = rst_req;
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R3 reset state
    check(rst_req == 1'b0, "R3 rst_req idle", {31'd0, rst_req}, 0);
    check(soft_mode == 1'b0, "R3 soft_mode", {31'd0, soft_mode}, 0);
    check(iso_en == 32'hFFFF_FFFF, "R3 iso_en", iso_en, 32'hFFFF_FFFF);
    xfer(0, 4'h0, 0, 32'h0, "R3 cause reset");
    xfer(0, 4'h4, 0, 32'h0001_0000, "R3 ctrl reset");
    xfer(0, 4'h8, 0, 32'h0, "R3 cfg reset");
    xfer(0, 4'hC, 0, 32'hFFFF_FFFF, "R3 iso reset");

    // R6 locked write dropped, violation flagged; R11 clear
    xfer(1, 4'h8, 32'h0000_300F, 0, "R6 locked cfg write");
    xfer(0, 4'h8, 0, 32'h0, "R6 cfg unchanged");
    xfer(0, 4'h0, 0, 32'h8, "R6 violation set");
    xfer(1, 4'h0, 32'h0000_0008, 0, "R11 clear write");
    xfer(0, 4'h0, 0, 32'h0, "R11 cause cleared");

    // R4 unlock, R5 guard persists across other traffic, R13 iso
    xfer(1, 4'h4, 32'h0001_5A69, 0, "R4 key write");
    xfer(0, 4'h4, 0, 32'h0001_0001, "R4 ctrl unlocked");
    xfer(1, 4'hC, 32'h0, 0, "R13 iso write");
    xfer(0, 4'hC, 0, 32'h0, "R13 iso read");
    check(iso_en == 32'h0, "R13 iso_en cleared", iso_en, 0);
    xfer(0, 4'h0, 0, 32'h0, "R5 cause read while open");
    xfer(0, 4'h6, 0, 32'h0001_0001, "R2 alias ctrl still open R5");
    xfer(1, 4'h8, 32'h0000_300F, 0, "R12 cfg soft");
    check(soft_mode == 1'b1, "R12 soft_mode set", {31'd0, soft_mode}, 1);
    xfer(0, 4'h8, 0, 32'h0000_300F, "R12 cfg read");
    xfer(0, 4'h4, 0, 32'h0001_0000, "R5 relocked");
    xfer(1, 4'h8, 32'h0, 0, "R6 second locked write");
    xfer(0, 4'h8, 0, 32'h0000_300F, "R6 cfg kept");
    xfer(1, 4'h0, 32'hFFFF_FFFF, 0, "R11 clear all");

    // R7 trigger bit held high: no reset
    p0 = pulses;
    xfer(1, 4'h4, 32'h0000_5A69, 0, "R4 key with bit16 0");
    xfer(0, 4'h4, 0, 32'h0001_0001, "R4 key never triggers");
    xfer(1, 4'h4, 32'h0001_0001, 0, "R7 bit16 one");
    drain();
    check(pulses == p0, "R7 no pulse", pulses, p0);
    xfer(0, 4'h4, 0, 32'h0001_0000, "R7 relocked");
    xfer(0, 4'h0, 0, 32'h0, "R7 no violation");

    // R7/R8 software reset
    xfer(1, 4'h4, 32'h0001_5A69, 0, "R7 key");
    xfer(1, 4'h4, 32'h0000_0001, 0, "R7 trigger");
    xfer(0, 4'h4, 0, 32'h0000_0000, "R8 bit16 low in pulse");
    wait_pulse_end();
    drain();
    check(pulses == p0 + 1, "R8 one pulse", pulses, p0 + 1);
    check(last_len == 16, "R8 pulse length", last_len, 16);
    xfer(0, 4'h0, 0, 32'h1, "R10 software cause");
    xfer(0, 4'h4, 0, 32'h0001_0000, "R8 bit16 back high");

    // R9 watchdog, external ignored while active
    p0 = pulses;
    @(negedge clk); wdog_req = 1'b1;
    @(negedge clk); wdog_req = 1'b0;
    repeat (4) @(negedge clk);
    ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    wait_pulse_end();
    check(pulses == p0 + 1, "R9 trigger ignored in pulse", pulses, p0 + 1);
    check(last_len == 16, "R8 watchdog pulse length", last_len, 16);
    xfer(0, 4'h0, 0, 32'h2, "R10 watchdog cause");

    // R10 violation kept across external pulse, R11 masked clear
    xfer(1, 4'h8, 32'h1234, 0, "R6 locked write again");
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    wait_pulse_end();
    xfer(0, 4'h0, 0, 32'hC, "R10 external with violation kept");
    xfer(1, 4'h0, 32'h4, 0, "R11 clear bit2");
    xfer(0, 4'h0, 0, 32'h8, "R11 only bit2 cleared");

    // R12 back to hard
    xfer(1, 4'h4, 32'h5A69, 0, "R12 key");
    xfer(1, 4'h8, 32'h0, 0, "R12 cfg hard");
    check(soft_mode == 1'b0, "R12 soft_mode hard", {31'd0, soft_mode}, 0);

    // R1 back-pressure
    bp = 1'b1;
    xfer(0, 4'h8, 0, 32'h0, "R1 bp cfg");
    xfer(0, 4'hC, 0, 32'h0, "R1 bp iso");
    xfer(0, 4'h0, 0, 32'h8, "R1 bp cause");
    xfer(0, 4'h4, 0, 32'h0001_0000, "R1 bp ctrl");
    xfer(1, 4'hC, 32'hA5A5_0F0F, 0, "R1 bp write");
    xfer(0, 4'hD, 0, 32'hA5A5_0F0F, "R2 alias iso");
    drain();
    bp = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1 all responses", exp_q.size(), 0);
    finish_run();
  end
endmodule